// File: doc/BRIEF.md
# Control Register Flush Controller

This block keeps the paging and mode control registers of a 32-bit core and the state of the gate that forces address bit 20 low. Software writes reach it as a register index together with a 32-bit data word. The gate state comes in as a level input. The block stores every value it is given. It also raises a flush request for the translation cache only when the cached translations are no longer valid.

Two pulse outputs carry the flush requests. One empties the whole cache, global entries included. The other drops only the non-global entries. A change to a paging-relevant bit of the mode registers, or a change of the gate state, asks for the whole cache to be emptied. Loading a new page-table base asks for the lighter flush, and only while paging is enabled. The block also drives the 32-bit address mask that matches the gate state and two hidden mode flags derived from the protection-enable bit. Every stored register can be read back through a read port.

Top module: `cr_flush_ctl`

## Requirements
- R1: While reset is applied, and in the cycle that follows its last active edge, the outputs show register 0 = 0x60000010, all other registers = 0, mask = 0xFFFFFFFF, protected flag = 0 and base-add flag = 1. The full flush output is 1 while reset is applied and returns to 0 after the first edge with reset low.
- R2: A write to index 0 always stores the data. It raises a full flush when bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) of the new value differs from the stored value.
- R3: A write to index 0 that changes only bits other than 31, 16 and 0 raises no flush.
- R4: A write to index 3 always stores the data. It raises the non-global flush only if bit 31 of register 0 is 1 at the time of the write. It never raises the full flush by itself.
- R5: A write to index 4 always stores the data. It raises a full flush only when bit 4, 5 or 7 changes. A change of any other bit raises no flush.
- R6: A write to index 1, 2, 5, 6 or 7 stores the data, readable on the read port at that index. It raises no flush and leaves registers 0, 3 and 4 unchanged.
- R7: The mask equals 0xFFEFFFFF with bit 20 set to the gate enable. A change of the enable updates the mask and raises a full flush one cycle later. Holding the enable at the state already in bit 20 raises no flush.
- R8: After a write to index 0, the protected flag equals the new bit 0 and the base-add flag equals its inverse.
- R9: The flush outputs are one-cycle pulses, high in the cycle after the clock edge that samples the cause. When both flushes are triggered in the same cycle, only the full flush is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Register index of the write |
| wr_data | input | 32 | Write data |
| a20_en | input | 1 | Gate enable level for address bit 20 |
| rd_idx | input | 3 | Read-back index |
| rd_data | output | 32 | Stored value at rd_idx |
| cr0_o | output | 32 | Register 0 |
| cr3_o | output | 32 | Register 3 |
| cr4_o | output | 32 | Register 4 |
| addr_mask_o | output | 32 | Address mask |
| prot_mode_o | output | 1 | Protected-mode hidden flag |
| seg_add_o | output | 1 | Segment base-add hidden flag |
| flush_all_o | output | 1 | Full flush pulse |
| flush_local_o | output | 1 | Non-global flush pulse |

## Verification
The bench targets the borders of the flush policy. It changes a single bit of register 0 that lies outside the watched group. A design that compared whole words would flush too often. It flips each watched bit on its own, including write protect, which is easy to leave out of the compare. It loads the table base with paging both on and off. A design that tested the new value, or ignored the paging bit, would flush at the wrong time. It also makes a table-base load and a gate change fall in the same cycle, so a design that raises both pulses, or lets the light flush win, is exposed.

// File: rtl/cr_flush_pkg.sv
package cr_flush_pkg;
  localparam int DW      = 32;
  localparam int N_CR    = 8;
  localparam int IDX_W   = $clog2(N_CR);
  localparam int IDX_MODE  = 0;
  localparam int IDX_TBASE = 3;
  localparam int IDX_EXT   = 4;
  localparam int B_PE  = 0;
  localparam int B_WP  = 16;
  localparam int B_PG  = 31;
  localparam int B_PSE = 4;
  localparam int B_PAE = 5;
  localparam int B_PGE = 7;
  localparam int A20_BIT = 20;
  localparam logic [DW-1:0] MODE_RST = 32'h6000_0010;
  localparam logic [DW-1:0] MODE_WATCH = (32'h1 << B_PG) | (32'h1 << B_WP) | (32'h1 << B_PE);
  localparam logic [DW-1:0] EXT_WATCH  = (32'h1 << B_PGE) | (32'h1 << B_PAE) | (32'h1 << B_PSE);

  function automatic logic [DW-1:0] rst_value(input int idx);
    return (idx == IDX_MODE) ? MODE_RST : '0;
  endfunction
endpackage

// File: rtl/cr_file.sv
module cr_file
  import cr_flush_pkg::*;
#(
  parameter int NREG = N_CR,
  parameter int W    = DW,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [W-1:0]           wr_data,
  output logic [NREG-1:0][W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_o[g] <= rst_value(g);
      else if (wr_en && wr_idx == IW'(g)) regs_o[g] <= wr_data;
    end
  end

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> regs_o[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/flush_decide.sv
module flush_decide
  import cr_flush_pkg::*;
#(
  parameter int W  = DW,
  parameter int IW = IDX_W
) (
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  mode_cur,
  input  logic [W-1:0]  ext_cur,
  output logic          want_all,
  output logic          want_local
);
  logic mode_hit, ext_hit, tbase_hit;

  always_comb begin
    mode_hit  = wr_en && wr_idx == IW'(IDX_MODE) &&
                ((wr_data & MODE_WATCH) != (mode_cur & MODE_WATCH));
    ext_hit   = wr_en && wr_idx == IW'(IDX_EXT) &&
                ((wr_data & EXT_WATCH) != (ext_cur & EXT_WATCH));
    tbase_hit = wr_en && wr_idx == IW'(IDX_TBASE) && mode_cur[B_PG];
    want_all   = mode_hit || ext_hit;
    want_local = tbase_hit;
  end
endmodule

// File: rtl/a20_gate.sv
module a20_gate
  import cr_flush_pkg::*;
#(
  parameter int W   = DW,
  parameter int BIT = A20_BIT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] mask_o,
  output logic         change_o
);
  localparam logic [W-1:0] BASE = ~(W'(1) << BIT);

  assign change_o = (en != mask_o[BIT]);

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '1;
    else if (change_o) mask_o <= BASE | (W'(en) << BIT);
  end

  assert_mask_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    (mask_o | ~BASE) == '1);
  assert_mask_follows_R7: assert property (@(posedge clk) disable iff (rst)
    change_o |=> mask_o[BIT] == $past(en));
endmodule

// File: rtl/cr_flush_ctl.sv
module cr_flush_ctl
  import cr_flush_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             a20_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    cr0_o,
  output logic [DW-1:0]    cr3_o,
  output logic [DW-1:0]    cr4_o,
  output logic [DW-1:0]    addr_mask_o,
  output logic             prot_mode_o,
  output logic             seg_add_o,
  output logic             flush_all_o,
  output logic             flush_local_o
);
  logic [N_CR-1:0][DW-1:0] regs;
  logic want_all, want_local, a20_change;

  cr_file #(.NREG(N_CR), .W(DW)) u_file (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs));

  flush_decide #(.W(DW), .IW(IDX_W)) u_decide (
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mode_cur(regs[IDX_MODE]), .ext_cur(regs[IDX_EXT]),
    .want_all(want_all), .want_local(want_local));

  a20_gate #(.W(DW), .BIT(A20_BIT)) u_a20 (
    .clk(clk), .rst(rst), .en(a20_en),
    .mask_o(addr_mask_o), .change_o(a20_change));

  assign cr0_o   = regs[IDX_MODE];
  assign cr3_o   = regs[IDX_TBASE];
  assign cr4_o   = regs[IDX_EXT];
  assign rd_data = regs[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_all_o   <= 1'b1;
      flush_local_o <= 1'b0;
      prot_mode_o   <= MODE_RST[B_PE];
      seg_add_o     <= ~MODE_RST[B_PE];
    end else begin
      flush_all_o   <= want_all || a20_change;
      flush_local_o <= want_local && !(want_all || a20_change);
      if (wr_en && wr_idx == IDX_W'(IDX_MODE)) begin
        prot_mode_o <= wr_data[B_PE];
        seg_add_o   <= ~wr_data[B_PE];
      end
    end
  end

  assert_one_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    !(flush_all_o && flush_local_o));
  assert_flags_R8: assert property (@(posedge clk) disable iff (rst)
    prot_mode_o == cr0_o[B_PE] && seg_add_o == !cr0_o[B_PE]);
  assert_tbase_no_paging_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(IDX_TBASE) && !cr0_o[B_PG]) |=> !flush_local_o);
  assert_gate_flush_R7: assert property (@(posedge clk) disable iff (rst)
    (addr_mask_o[A20_BIT] != $past(addr_mask_o[A20_BIT])) |-> flush_all_o);
  assert_quiet_mode_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(IDX_MODE) && !a20_change &&
     ((wr_data ^ cr0_o) & MODE_WATCH) == '0) |=> !flush_all_o);
endmodule

// File: tb/cr_flush_ctl_bench.sv
module cr_flush_ctl_bench;
  logic clk = 0, rst = 1, wr_en = 0, a20_en = 1;
  logic [2:0] wr_idx = 0, rd_idx = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data, cr0_o, cr3_o, cr4_o, addr_mask_o;
  logic prot_mode_o, seg_add_o, flush_all_o, flush_local_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cr_flush_ctl u_cr_flush_ctl (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulses(string req, logic a, logic l);
    chk(req, "flush_all", 32'(flush_all_o), 32'(a));
    chk(req, "flush_local", 32'(flush_local_o), 32'(l));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "flush_all in reset", 32'(flush_all_o), 1);
    rst = 0;
    @(negedge clk);
    chk("R1", "cr0", cr0_o, 32'h6000_0010);
    chk("R1", "cr3", cr3_o, 0);
    chk("R1", "cr4", cr4_o, 0);
    chk("R1", "mask", addr_mask_o, 32'hFFFF_FFFF);
    chk("R1", "prot", 32'(prot_mode_o), 0);
    chk("R1", "segadd", 32'(seg_add_o), 1);
    pulses("R1", 0, 0);
  endtask

  task automatic t_mode();
    wr(0, 32'h6000_0011);
    pulses("R2", 1, 0);
    chk("R2", "cr0", cr0_o, 32'h6000_0011);
    chk("R8", "prot", 32'(prot_mode_o), 1);
    chk("R8", "segadd", 32'(seg_add_o), 0);
    @(negedge clk);
    pulses("R9", 0, 0);
    wr(0, 32'h6000_0031);
    pulses("R3", 0, 0);
    chk("R3", "cr0", cr0_o, 32'h6000_0031);
    wr(0, 32'hE000_0031);
    pulses("R2", 1, 0);
    wr(0, 32'hE001_0031);
    pulses("R2", 1, 0);
  endtask

  task automatic t_tbase();
    wr(3, 32'h0000_1000);
    pulses("R4", 0, 1);
    chk("R4", "cr3", cr3_o, 32'h0000_1000);
    @(negedge clk);
    pulses("R9", 0, 0);
    wr(0, 32'h6001_0031);
    pulses("R2", 1, 0);
    wr(3, 32'h0000_2000);
    pulses("R4", 0, 0);
    chk("R4", "cr3", cr3_o, 32'h0000_2000);
    wr(0, 32'hE001_0031);
  endtask

  task automatic t_ext();
    wr(4, 32'h10);
    pulses("R5", 1, 0);
    wr(4, 32'h110);
    pulses("R5", 0, 0);
    chk("R5", "cr4", cr4_o, 32'h110);
    wr(4, 32'h130);
    pulses("R5", 1, 0);
    wr(4, 32'hB0);
    pulses("R5", 1, 0);
    chk("R5", "cr4", cr4_o, 32'hB0);
  endtask

  task automatic t_other();
    wr(2, 32'hDEAD_BEEF);
    pulses("R6", 0, 0);
    rd_idx = 2;
    #1 chk("R6", "rd2", rd_data, 32'hDEAD_BEEF);
    wr(7, 32'h1234_5678);
    pulses("R6", 0, 0);
    rd_idx = 7;
    #1 chk("R6", "rd7", rd_data, 32'h1234_5678);
    chk("R6", "cr0", cr0_o, 32'hE001_0031);
    chk("R6", "cr3", cr3_o, 32'h0000_2000);
    chk("R6", "cr4", cr4_o, 32'hB0);
  endtask

  task automatic t_gate();
    a20_en = 0;
    @(negedge clk);
    chk("R7", "mask off", addr_mask_o, 32'hFFEF_FFFF);
    pulses("R7", 1, 0);
    @(negedge clk);
    pulses("R7", 0, 0);
    chk("R7", "mask held", addr_mask_o, 32'hFFEF_FFFF);
    a20_en = 1;
    @(negedge clk);
    chk("R7", "mask on", addr_mask_o, 32'hFFFF_FFFF);
    pulses("R7", 1, 0);
  endtask

  task automatic t_prio();
    a20_en = 0;
    wr(3, 32'h0000_3000);
    pulses("R9", 1, 0);
    chk("R9", "cr3", cr3_o, 32'h0000_3000);
    @(negedge clk);
    pulses("R9", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mode();
    t_tbase();
    t_ext();
    t_other();
    t_gate();
    t_prio();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule